// File: doc/BRIEF.md
# Bit-Swapping Low-Transition Pattern Generator

This block produces pseudo-random test words for a scan or parallel test interface while lowering the number of 0/1 changes that each output cell sees from one word to the next. At its core is a shift register with linear feedback that walks through every nonzero state before repeating. Its parallel value does not go straight to the output. A layer of 2:1 multiplexers sits in between, and the most significant register stage steers all of them. When that stage holds 0, each neighbouring pair of low-order bits is exchanged. When it holds 1, every bit passes through unchanged.

Because the steering bit itself is never exchanged, the mapping from register state to output word is one-to-one. Over one period the block therefore emits exactly the same set of words as the plain register, only in a different bit arrangement. For a pair of cells where one is the shifted copy of the other, the exchange removes about a quarter of the changes.

The register steps when enabled and holds otherwise. A seed load overrides stepping. A zero seed is replaced by a fixed nonzero value so that the register can never lock up. The most significant stage is also driven out as a serial bit stream.

Top module: `bslfsr_gen`

## Requirements
- R1: While synchronous active-high reset is asserted, the register takes the value 1 (only bit 0 set). For WIDTH=8 this gives `word_o` = 0x02 and `scan_o` = 0.
- R2: When `load_i` and `en_i` are both low, the register and both outputs keep their values on the next clock.
- R3: When `load_i` is high and `seed_i` is nonzero, the register equals `seed_i` after the clock, whatever the value of `en_i`.
- R4: When `load_i` is high and `seed_i` is zero, the register takes the value 1 instead.
- R5: When `en_i` is high and `load_i` is low, the register shifts up by one bit. Bit 0 receives the XOR of the stages selected by `TAPS`, and the default mask for WIDTH=8 is 0xB8. `scan_o` always equals the top stage, bit WIDTH-1.
- R6: When the top stage is 1, `word_o` equals the register bit for bit.
- R7: When the top stage is 0, output bits 2k and 2k+1 are exchanged for k = 0 .. (WIDTH-1)/2-1 (integer division). All higher bits pass through unchanged, so for WIDTH=8 bits 6 and 7 are never exchanged.
- R8: With continuous stepping, the register never reaches zero and returns to its start value after exactly 2^WIDTH-1 steps.
- R9: Over one full period, the output words are all distinct and nonzero, so they form a permutation of the register states.
- R10: Over one full period, including the wrap, the total count of bit changes between consecutive `word_o` values is lower than the count for the un-swapped register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Step the register by one state |
| load_i | input | 1 | Load `seed_i`; takes priority over `en_i` |
| seed_i | input | WIDTH | Seed value; zero is replaced by 1 |
| word_o | output | WIDTH | Bit-swapped parallel pattern |
| scan_o | output | 1 | Serial output, the top register stage |

## Verification
The in-RTL assertions check the per-cycle rules on every clock: hold, load priority, substitution of a zero seed, the shift relation, the state never being zero, pass-through when the steering bit is 1, and equal popcount between the output word and the register. The properties that cover a whole period can only be shown by the bench's scenarios. These are the return to the start value after 2^WIDTH-1 steps, the distinctness of the output words, and the lower transition count against the un-swapped sequence. The bench reconstructs each register value from the output word by undoing the exchange and tallies both transition counts over one full cycle.

// File: rtl/bslfsr_pkg.sv
package bslfsr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_STEP = 2'd1,
        OP_LOAD = 2'd2
    } lfsr_op_e;

    typedef struct packed {
        logic en;
        logic load;
    } lfsr_ctrl_t;

    // Feedback mask (bit k set means stage k+1 feeds back) giving a
    // maximal-length sequence for widths 3 to 16.
    function automatic logic [63:0] default_taps(input int w);
        case (w)
            3:       return 64'h6;
            4:       return 64'hC;
            5:       return 64'h14;
            6:       return 64'h30;
            7:       return 64'h60;
            8:       return 64'hB8;
            9:       return 64'h110;
            10:      return 64'h240;
            11:      return 64'h500;
            12:      return 64'h829;
            13:      return 64'h100D;
            14:      return 64'h2015;
            15:      return 64'h6000;
            16:      return 64'hD008;
            default: return 64'hB8;
        endcase
    endfunction

    // Number of neighbouring output pairs that get exchanged.
    function automatic int swap_pairs(input int w);
        return (w - 1) / 2;
    endfunction

    function automatic lfsr_op_e decode_op(input lfsr_ctrl_t c);
        if (c.load)
            return OP_LOAD;
        else if (c.en)
            return OP_STEP;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/bslfsr_core.sv
module bslfsr_core
    import bslfsr_pkg::*;
#(
    parameter int          WIDTH = 8,
    parameter logic [63:0] TAPS  = default_taps(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] seed_i,
    output logic [WIDTH-1:0] state_o
);
    localparam logic [WIDTH-1:0] TAP_MASK  = TAPS[WIDTH-1:0];
    localparam logic [WIDTH-1:0] SAFE_SEED = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;
    logic             fb_bit;
    lfsr_ctrl_t       ctrl;
    lfsr_op_e         op;

    assign ctrl   = '{en: en_i, load: load_i};
    assign op     = decode_op(ctrl);
    assign fb_bit = ^(state_q & TAP_MASK);

    always_comb begin
        state_d = state_q;
        unique case (op)
            OP_LOAD: state_d = (seed_i == '0) ? SAFE_SEED : seed_i;
            OP_STEP: state_d = {state_q[WIDTH-2:0], fb_bit};
            default: state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= SAFE_SEED;
        else
            state_q <= state_d;
    end

    assign state_o = state_q;

    // R2: idle cycles keep the state
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !load_i) |=> $stable(state_q));

    // R3: nonzero seed is taken regardless of enable
    a_r3_load: assert property (@(posedge clk) disable iff (rst)
        (load_i && seed_i != '0) |=> (state_q == $past(seed_i)));

    // R4: zero seed is replaced
    a_r4_zero_seed: assert property (@(posedge clk) disable iff (rst)
        (load_i && seed_i == '0) |=> (state_q == SAFE_SEED));

    // R5: stepping shifts the register up by one
    a_r5_shift: assert property (@(posedge clk) disable iff (rst)
        (en_i && !load_i) |=> (state_q[WIDTH-1:1] == $past(state_q[WIDTH-2:0])));

    // R8: lock-up state never reached
    a_r8_nonzero: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

endmodule

// File: rtl/bslfsr_swap.sv
module bslfsr_swap
    import bslfsr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] word_o
);
    localparam int NPAIRS = swap_pairs(WIDTH);
    localparam int NSWAP  = 2 * NPAIRS;

    logic steer;
    assign steer = raw_i[WIDTH-1];

    for (genvar k = 0; k < WIDTH; k++) begin : g_cell
        if (k < NSWAP) begin : g_pair
            if ((k % 2) == 0) begin : g_lo
                assign word_o[k] = steer ? raw_i[k] : raw_i[k+1];
            end else begin : g_hi
                assign word_o[k] = steer ? raw_i[k] : raw_i[k-1];
            end
        end else begin : g_pass
            assign word_o[k] = raw_i[k];
        end
    end

endmodule

// File: rtl/bslfsr_gen.sv
module bslfsr_gen
    import bslfsr_pkg::*;
#(
    parameter int          WIDTH = 8,
    parameter logic [63:0] TAPS  = default_taps(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] seed_i,
    output logic [WIDTH-1:0] word_o,
    output logic             scan_o
);
    logic [WIDTH-1:0] state;

    bslfsr_core #(.WIDTH(WIDTH), .TAPS(TAPS)) u_core (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en_i),
        .load_i  (load_i),
        .seed_i  (seed_i),
        .state_o (state)
    );

    bslfsr_swap #(.WIDTH(WIDTH)) u_swap (
        .raw_i  (state),
        .word_o (word_o)
    );

    assign scan_o = state[WIDTH-1];

    // R6: steering bit high means straight pass-through
    a_r6_pass: assert property (@(posedge clk) disable iff (rst)
        state[WIDTH-1] |-> (word_o == state));

    // R9: exchange only rearranges bits, so weight is preserved
    a_r9_weight: assert property (@(posedge clk) disable iff (rst)
        $countones(word_o) == $countones(state));

    // R7: steering bit is never exchanged
    a_r7_steer_kept: assert property (@(posedge clk) disable iff (rst)
        word_o[WIDTH-1] == scan_o);

endmodule

// File: tb/tb_bslfsr_gen.sv
module tb_bslfsr_gen;
    localparam int W      = 8;
    localparam int PERIOD = (1 << W) - 1;
    localparam logic [W-1:0] TAPM = 8'hB8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en_i = 1'b0;
    logic         load_i = 1'b0;
    logic [W-1:0] seed_i = '0;
    logic [W-1:0] word_o;
    logic         scan_o;

    int errors = 0;
    int checks = 0;
    logic [W-1:0] model;

    bslfsr_gen #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .en_i(en_i), .load_i(load_i),
        .seed_i(seed_i), .word_o(word_o), .scan_o(scan_o)
    );

    always #10 clk = ~clk;

    function automatic logic [W-1:0] f_step(input logic [W-1:0] s);
        return {s[W-2:0], ^(s & TAPM)};
    endfunction

    // Exchange is its own inverse, so one function serves both ways.
    function automatic logic [W-1:0] f_swap(input logic [W-1:0] s);
        logic [W-1:0] r;
        r = s;
        if (!s[W-1])
            for (int k = 0; k < (W-1)/2; k++) begin
                r[2*k]   = s[2*k+1];
                r[2*k+1] = s[2*k];
            end
        return r;
    endfunction

    task automatic chk(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic r, input logic e, input logic l,
                        input logic [W-1:0] s);
        @(negedge clk);
        rst = r; en_i = e; load_i = l; seed_i = s;
        @(posedge clk);
        #1;
        if (r)       model = 1;
        else if (l)  model = (s == '0) ? 1 : s;
        else if (e)  model = f_step(model);
    endtask

    task automatic cmp(input string req);
        chk(word_o == f_swap(model), req, word_o, f_swap(model));
        chk(scan_o == model[W-1], {req, " scan"}, scan_o, model[W-1]);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] words [PERIOD];
        logic         seen [1 << W];
        logic [W-1:0] held;
        int           tr_sw, tr_pl, dup, zero;
        void'($urandom(32'd4242));
        model = 1;

        // R1 reset value
        tick(1, 1, 0, 8'h00);
        tick(1, 0, 1, 8'h55);
        chk(word_o == 8'h02, "R1 word", word_o, 8'h02);
        chk(scan_o == 1'b0, "R1 scan", scan_o, 0);

        // R5 first steps from reset
        tick(0, 1, 0, 0);
        cmp("R5 step1");
        tick(0, 1, 0, 0);
        cmp("R5 step2");

        // R2 hold
        held = word_o;
        tick(0, 0, 0, 8'hFF);
        tick(0, 0, 0, 8'h00);
        chk(word_o == held, "R2 hold", word_o, held);

        // R3 load beats enable
        tick(0, 1, 1, 8'hC3);
        chk(word_o == 8'hC3, "R3 load with en", word_o, 8'hC3);
        chk(scan_o == 1'b1, "R3 scan", scan_o, 1);

        // R6 top bit set: pass-through
        tick(0, 0, 1, 8'hA9);
        chk(word_o == 8'hA9, "R6 pass", word_o, 8'hA9);

        // R7 top bit clear: pairs (0,1),(2,3),(4,5) exchanged, 6,7 kept
        tick(0, 0, 1, 8'h65);
        chk(word_o == 8'h5A, "R7 swap 0x65", word_o, 8'h5A);
        tick(0, 0, 1, 8'h41);
        chk(word_o == 8'h42, "R7 swap 0x41", word_o, 8'h42);

        // R4 zero seed
        tick(0, 0, 1, 8'h00);
        chk(word_o == 8'h02, "R4 zero seed", word_o, 8'h02);

        // R1 reset during stepping
        tick(0, 1, 0, 0);
        tick(0, 1, 0, 0);
        tick(1, 1, 0, 0);
        chk(word_o == 8'h02, "R1 mid reset", word_o, 8'h02);

        // Random mix of R2, R3, R4, R5
        for (int i = 0; i < 600; i++) begin
            int sel;
            logic [W-1:0] sd;
            sel = $urandom_range(0, 9);
            sd  = (sel == 9) ? '0 : W'($urandom());
            tick(0, sel > 2, sel == 0 || sel == 9, sd);
            cmp("R5 random");
        end

        // Full period: R8, R9, R10
        tick(0, 0, 1, 8'h01);
        for (int i = 0; i < (1 << W); i++) seen[i] = 1'b0;
        dup = 0; zero = 0; tr_sw = 0; tr_pl = 0;
        for (int i = 0; i < PERIOD; i++) begin
            words[i] = word_o;
            if (word_o == '0) zero++;
            if (seen[word_o]) dup++;
            seen[word_o] = 1'b1;
            if (i > 0) begin
                tr_sw += $countones(words[i] ^ words[i-1]);
                tr_pl += $countones(f_swap(words[i]) ^ f_swap(words[i-1]));
            end
            tick(0, 1, 0, 0);
        end
        tr_sw += $countones(words[0] ^ words[PERIOD-1]);
        tr_pl += $countones(f_swap(words[0]) ^ f_swap(words[PERIOD-1]));
        chk(word_o == words[0], "R8 period", word_o, words[0]);
        chk(zero == 0, "R8 nonzero", zero, 0);
        chk(dup == 0, "R9 distinct", dup, 0);
        chk(tr_sw < tr_pl, "R10 fewer transitions", tr_sw, tr_pl);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule